// File: doc/BRIEF.md
# Little-Endian Byte-Lane Steering Unit

This block sits between a 32-bit register datapath and a word-wide data memory and handles every sub-word detail of a load or store. On a store it turns the access size and the low byte-address bits into a per-lane write-enable mask and builds write data in which the store value is copied across the lanes. The memory can then latch whichever lanes are enabled. On a load it takes the full word read from memory, picks out the addressed byte or halfword and zero-extends it to 32 bits.

Lane numbering is little-endian: lane k holds the byte at byte address offset k, and lane 0 carries bits 7:0. Words must sit on multiples of 4 and halfwords on multiples of 2. An access that breaks this rule raises an error flag, enables no lane and returns zero data. The inputs are registered once, so every output reflects the request that was present at the previous rising clock edge.

Top module: `lane_steer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all outputs are zero (`lane_we`=0, `wr_data`=0, `ld_data`=0, `misalign`=0).
- R2: A byte store (`acc_size`=2'b00) at offset a sets only `lane_we` bit a, and `wr_data` holds `st_data[7:0]` copied into all four lanes.
- R3: A halfword store (`acc_size`=2'b01) at offset 0 sets `lane_we`=4'b0011 and at offset 2 sets 4'b1100; `wr_data` holds `st_data[15:0]` in both halves.
- R4: A word store (`acc_size`=2'b10) at offset 0 sets `lane_we`=4'b1111 with `wr_data`=`st_data`.
- R5: A halfword access at an odd offset, or a word access at a non-zero offset, sets `misalign`=1 with `lane_we`=0, `wr_data`=0 and `ld_data`=0.
- R6: A load (`is_store`=0) never sets any `lane_we` bit and drives `wr_data`=0; a store drives `ld_data`=0.
- R7: A byte load at offset a returns `rd_data[8a+7:8a]` in bits 7:0 of `ld_data`, with 24 zero bits above it.
- R8: A halfword load returns `rd_data[15:0]` at offset 0 or `rd_data[31:16]` at offset 2 in bits 15:0, with 16 zero bits above it.
- R9: A word load at offset 0 returns `rd_data` unchanged.
- R10: The reserved size code 2'b11 is treated as misaligned, with the same outputs as in R5.
- R11: Every output changes one clock after the request: the values seen after rising edge k come only from the inputs sampled at edge k.
- R12: With memory words 0x00040302 at word 0 and 0x00000005 at word 1, byte loads at byte addresses 0 to 4 return 2, 3, 4, 0 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| is_store | input | 1 | 1 = store, 0 = load |
| addr_lo | input | 2 | Byte offset within the word |
| st_data | input | 32 | Register data to be stored |
| rd_data | input | 32 | Word read from memory |
| lane_we | output | 4 | Per-byte-lane write enable |
| wr_data | output | 32 | Lane-replicated write data |
| ld_data | output | 32 | Zero-extended load result |
| misalign | output | 1 | Alignment error |

## Verification
The bench builds the block with its default parameters of four 8-bit lanes. With those values the 2-bit offset and all four size codes can be covered in full. Random requests therefore reach every pair of offset and size, for loads and for stores, and also the reserved code. Directed cases pin down each halfword mask and every misaligned offset. The byte-by-byte readback pattern across two adjacent words is also driven directly.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk
    import lane_steer_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [1:0]       size,
    input  logic [OFS_W-1:0] ofs,
    output logic             bad
);
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = (ofs[OFS_W-2:0] != '0);
            SZ_WORD: bad = (ofs != '0);
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lane_store_fmt.sv
module lane_store_fmt
    import lane_steer_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int OFS_W  = $clog2(LANES),
    localparam int HALF_L = LANES / 2
) (
    input  logic [1:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] sdata,
    output logic [LANES-1:0]  we,
    output logic [DATA_W-1:0] wdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (acc_size_e'(size))
                SZ_BYTE: begin
                    we[i] = (ofs == OFS_W'(i));
                    wdata[i*LANE_W +: LANE_W] = sdata[LANE_W-1:0];
                end
                SZ_HALF: begin
                    we[i] = (ofs[OFS_W-1] == 1'((i / HALF_L)));
                    wdata[i*LANE_W +: LANE_W] = sdata[(i % HALF_L)*LANE_W +: LANE_W];
                end
                SZ_WORD: begin
                    we[i] = 1'b1;
                    wdata[i*LANE_W +: LANE_W] = sdata[i*LANE_W +: LANE_W];
                end
                default: begin
                    we[i] = 1'b0;
                    wdata[i*LANE_W +: LANE_W] = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lane_load_ext.sv
module lane_load_ext
    import lane_steer_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int OFS_W  = $clog2(LANES),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [1:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ldata
);
    logic [LANE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;

    always_comb begin
        byte_sel = rdata[int'(ofs)*LANE_W +: LANE_W];
        half_sel = ofs[OFS_W-1] ? rdata[DATA_W-1:HALF_W] : rdata[HALF_W-1:0];
        unique case (acc_size_e'(size))
            SZ_BYTE: ldata = {{(DATA_W-LANE_W){1'b0}}, byte_sel};
            SZ_HALF: ldata = {{(DATA_W-HALF_W){1'b0}}, half_sel};
            SZ_WORD: ldata = rdata;
            default: ldata = '0;
        endcase
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_steer_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_size,
    input  logic              is_store,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  lane_we,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ld_data,
    output logic              misalign
);
    typedef struct packed {
        logic [LANES-1:0]  we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] ldata;
        logic              err;
        logic [1:0]        size;
        logic              store;
        logic              hi;
    } state_t;

    state_t st_d, st_q;

    logic              bad;
    logic [LANES-1:0]  fmt_we;
    logic [DATA_W-1:0] fmt_wdata;
    logic [DATA_W-1:0] ext_data;

    lane_align_chk #(.LANES(LANES)) u_chk (
        .size(acc_size), .ofs(addr_lo), .bad(bad)
    );

    lane_store_fmt #(.LANE_W(LANE_W), .LANES(LANES)) u_st (
        .size(acc_size), .ofs(addr_lo), .sdata(st_data),
        .we(fmt_we), .wdata(fmt_wdata)
    );

    lane_load_ext #(.LANE_W(LANE_W), .LANES(LANES)) u_ld (
        .size(acc_size), .ofs(addr_lo), .rdata(rd_data), .ldata(ext_data)
    );

    always_comb begin
        st_d       = '0;
        st_d.err   = bad;
        st_d.size  = acc_size;
        st_d.store = is_store;
        st_d.hi    = addr_lo[OFS_W-1];
        if (!bad) begin
            if (is_store) begin
                st_d.we    = fmt_we;
                st_d.wdata = fmt_wdata;
            end else begin
                st_d.ldata = ext_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_we  = st_q.we;
    assign wr_data  = st_q.wdata;
    assign ld_data  = st_q.ldata;
    assign misalign = st_q.err;

    AST_ERR_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> (st_q.we == '0 && st_q.ldata == '0)); // R5
    AST_LOAD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.store |-> (st_q.we == '0 && st_q.wdata == '0)); // R6
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.store && st_q.size == SZ_BYTE) |-> $countones(st_q.we) == 1); // R2
    AST_HALF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.store && st_q.size == SZ_HALF && !st_q.err) |->
        ($countones(st_q.we) == LANES/2 && st_q.we[LANES-1] == st_q.hi)); // R3
    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.store && st_q.size == SZ_BYTE) |-> st_q.ldata[DATA_W-1:LANE_W] == '0); // R7
    AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.size == SZ_RSVD) |-> st_q.err); // R10
endmodule

// File: tb/lane_steer_bench.sv
`timescale 1ns/1ps
module lane_steer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  acc_size;
    logic        is_store;
    logic [1:0]  addr_lo;
    logic [31:0] st_data, rd_data;
    logic [3:0]  lane_we;
    logic [31:0] wr_data, ld_data;
    logic        misalign;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lane_steer u_lane_steer (
        .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .is_store(is_store),
        .addr_lo(addr_lo), .st_data(st_data), .rd_data(rd_data),
        .lane_we(lane_we), .wr_data(wr_data), .ld_data(ld_data), .misalign(misalign)
    );

    function automatic logic exp_err(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00:   return 1'b0;
            2'b01:   return a[0];
            2'b10:   return a != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] exp_we(input logic [1:0] sz, input logic st, input logic [1:0] a);
        if (!st || exp_err(sz, a)) return 4'b0000;
        case (sz)
            2'b00:   return 4'b0001 << a;
            2'b01:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic st,
                                           input logic [1:0] a, input logic [31:0] d);
        if (!st || exp_err(sz, a)) return 32'h0;
        case (sz)
            2'b00:   return {4{d[7:0]}};
            2'b01:   return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic st,
                                           input logic [1:0] a, input logic [31:0] m);
        logic [31:0] sh;
        if (st || exp_err(sz, a)) return 32'h0;
        sh = m >> (8 * a);
        case (sz)
            2'b00:   return {24'h0, sh[7:0]};
            2'b01:   return {16'h0, sh[15:0]};
            default: return m;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [1:0] sz, input logic st, input logic [1:0] a);
        if (sz == 2'b11) return "R10";
        if (exp_err(sz, a)) return "R5";
        if (!st) return (sz == 2'b00) ? "R7" : (sz == 2'b01) ? "R8" : "R9";
        return (sz == 2'b00) ? "R2" : (sz == 2'b01) ? "R3" : "R4";
    endfunction

    // drive at negedge, one rising edge registers it, sample 1 ns later (R11)
    task automatic run(input logic [1:0] sz, input logic st, input logic [1:0] a,
                       input logic [31:0] d, input logic [31:0] m);
        string t;
        @(negedge clk);
        acc_size = sz; is_store = st; addr_lo = a; st_data = d; rd_data = m;
        @(posedge clk); #1;
        t = tag(sz, st, a);
        chk({t, " we"},   {28'h0, lane_we},  {28'h0, exp_we(sz, st, a)});
        chk({t, " wd R6"}, wr_data,          exp_wd(sz, st, a, d));
        chk({t, " ld R6"}, ld_data,          exp_ld(sz, st, a, m));
        chk({t, " err"},  {31'h0, misalign}, {31'h0, exp_err(sz, a)});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [31:0] mem [2];
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; acc_size = 2'b10; is_store = 1'b1; addr_lo = 2'b00;
        st_data = 32'hFFFF_FFFF; rd_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 we",  {28'h0, lane_we}, 32'h0);
        chk("R1 wd",  wr_data, 32'h0);
        chk("R1 ld",  ld_data, 32'h0);
        chk("R1 err", {31'h0, misalign}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // directed corners
        for (int a = 0; a < 4; a++) run(2'b00, 1'b1, 2'(a), 32'h1234_56A5, 32'h0); // R2
        run(2'b01, 1'b1, 2'd0, 32'hDEAD_BEEF, 32'h0);                            // R3
        run(2'b01, 1'b1, 2'd2, 32'hDEAD_BEEF, 32'h0);                            // R3
        run(2'b10, 1'b1, 2'd0, 32'hCAFE_F00D, 32'h0);                            // R4
        for (int a = 1; a < 4; a++) run(2'b10, 1'b0, 2'(a), 32'h0, 32'h8765_4321); // R5
        run(2'b01, 1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0);                            // R5
        run(2'b01, 1'b0, 2'd3, 32'h0, 32'hFFFF_FFFF);                            // R5
        run(2'b11, 1'b1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);                    // R10
        run(2'b01, 1'b0, 2'd2, 32'h0, 32'h8001_7FFE);                            // R8
        run(2'b10, 1'b0, 2'd0, 32'h0, 32'h8001_7FFE);                            // R9

        // R12: bytes 2,3,4 then an aligned word 5
        mem[0] = 32'h0004_0302; mem[1] = 32'h0000_0005;
        for (int b = 0; b < 5; b++) begin
            @(negedge clk);
            acc_size = 2'b00; is_store = 1'b0; addr_lo = 2'(b % 4);
            st_data = 32'h0; rd_data = mem[b / 4];
            @(posedge clk); #1;
            chk("R12 byte readback", ld_data, (b == 0) ? 32'd2 : (b == 1) ? 32'd3 :
                                              (b == 2) ? 32'd4 : (b == 3) ? 32'd0 : 32'd5);
        end

        // R11: back-to-back requests each seen one clock later
        for (int n = 0; n < 400; n++) begin
            run(2'($urandom), 1'($urandom), 2'($urandom), $urandom, $urandom);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule